// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing engine of a small byte-wide nonvolatile memory that answers on a two-wire serial bus (I2C style). The clock and data wires enter through two-flop synchronizers and are oversampled by the system clock. The engine finds start and stop conditions, compares the incoming device byte with a fixed type code and three strap inputs, and pulls the data line low to acknowledge.

Once selected for a write, the engine takes the first byte as the word address, which loads its internal pointer. Every later byte becomes a write strobe with address and data, which goes to a separate page-write controller and also updates the local array. Once selected for a read, it shifts out the byte at the pointer with the most significant bit first and advances the pointer. It keeps sending while the master acknowledges.

The pointer persists between transactions. This supports current-address reads, and also random reads, where the master sends a write-mode device byte and a word address, then a repeated start. A parameter shrinks the array from 256 to 128 bytes.

Top module: `ee_i2c_slave`

## Requirements
- R1: The device byte is selected when its bits 7:4 equal 1010 and bits 3:1 equal the three strap inputs (bit 3 = strap 2, bit 1 = strap 0). Bit 0 chooses the direction, with 1 for read and 0 for write. A selected device byte is acknowledged by holding SDA low through the ninth SCL clock. On a mismatch the engine never pulls SDA and makes no write until the next start.
- R2: A start (SDA falling while SCL is high) at any point, including in the middle of a byte, aborts the current transfer without a write and makes the engine wait for a new device byte. A stop (SDA rising while SCL is high) returns it to idle.
- R3: In a write, the first byte after the device acknowledge loads the pointer, and is acknowledged. Each following byte is acknowledged and produces one write strobe carrying the pointer value and the byte. A write that carries a word address and no data changes only the pointer.
- R4: After each written byte, the low three pointer bits advance modulo 8 and the upper bits stay fixed. Bytes beyond the eighth therefore wrap within the same 8-byte page and overwrite earlier bytes.
- R5: A read that is not preceded by a word address returns the byte at the pointer, which is one past the last location read or addressed.
- R6: A write-mode device byte, a word address and then a repeated start with a read-mode device byte return data beginning at that word address.
- R7: In a read, each master acknowledge (SDA low on the ninth clock) makes the engine send the next byte, and the pointer wraps from the last location to 0. A master non-acknowledge ends output, and SDA stays released.
- R8: With the 128-byte configuration, bit 7 of the word address is ignored (0x85 addresses location 5), and reads wrap from 127 to 0.
- R9: The output `sda_pull` (1 means SDA is pulled low) changes only while SCL is low. Each change comes one system clock after the synchronized SCL fall is detected. Data is sent with the most significant bit first.
- R10: During and right after reset, `sda_pull` and `wr_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus (wired-AND level) |
| dev_sel | input | 3 | Strap inputs compared with device byte bits 3:1 |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_stb | output | 1 | One-cycle strobe for each received data byte |
| wr_addr | output | PTR_W (8, or 7 when small) | Location of the strobed byte |
| wr_data | output | 8 | Strobed data byte |

## Verification
Most internal faults in this engine show up at SDA within one byte time. A wrong state or bit count either loses the acknowledge on the ninth clock of the byte in progress, or pulls SDA while the master drives it. A wrong pointer stays hidden until the next read, and then the very first data byte returned differs from the location the bench computed. For this reason, every full-array fill is followed by a sequential read that crosses the wrap point. A wrong page-wrap or address mask appears on `wr_addr` in the same ninth clock as the faulty byte.

// File: rtl/ee_slave_pkg.sv
package ee_slave_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WORD,
    ST_WORD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_MACK
  } ee_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;
  logic scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/ee_byte_array.sv
module ee_byte_array #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave
  import ee_slave_pkg::*;
#(
  parameter bit          SMALL_ARRAY = 1'b0,
  parameter int unsigned PAGE_BYTES  = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PTR_W      = SMALL_ARRAY ? 7 : 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [2:0]       dev_sel,
  output logic             sda_pull,
  output logic             wr_stb,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data
);

  localparam int unsigned PG_W = $clog2(PAGE_BYTES);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);

  logic sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;

  ee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  ee_state_e        st, st_n;
  logic [3:0]       cnt, cnt_n;
  logic [7:0]       rx, rx_n;
  logic [7:0]       tx, tx_n;
  logic [PTR_W-1:0] ptr, ptr_n;
  logic             drv, drv_n;
  logic             rw, rw_n;
  logic             mack, mack_n;
  logic             wstb_n;
  logic [PTR_W-1:0] waddr_q, waddr_n;
  logic [7:0]       wdata_q, wdata_n;
  logic [7:0]       rdata;
  logic [PG_W-1:0]  pg_lo;

  ee_byte_array #(.AW(PTR_W)) u_array (
    .clk   (clk),
    .we    (wr_stb),
    .waddr (waddr_q),
    .wdata (wdata_q),
    .raddr (ptr),
    .rdata (rdata)
  );

  assign pg_lo = ptr[PG_W-1:0] + PG_W'(1);

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    rx_n    = rx;
    tx_n    = tx;
    ptr_n   = ptr;
    drv_n   = drv;
    rw_n    = rw;
    mack_n  = mack;
    wstb_n  = 1'b0;
    waddr_n = waddr_q;
    wdata_n = wdata_q;
    if (bus_start) begin
      st_n  = ST_DEV;
      cnt_n = '0;
      drv_n = 1'b0;
    end else if (bus_stop) begin
      st_n  = ST_IDLE;
      drv_n = 1'b0;
    end else begin
      case (st)
        ST_DEV, ST_WORD, ST_WDATA: begin
          if (scl_rise && cnt < LAST_BIT) begin
            rx_n  = {rx[6:0], sda_lvl};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == LAST_BIT) begin
            if (st == ST_DEV) begin
              if (rx[7:4] == DEV_TYPE && rx[3:1] == dev_sel) begin
                drv_n = 1'b1;
                rw_n  = rx[0];
                st_n  = ST_DEV_ACK;
              end else begin
                st_n = ST_IDLE;
              end
            end else if (st == ST_WORD) begin
              drv_n = 1'b1;
              ptr_n = rx[PTR_W-1:0];
              st_n  = ST_WORD_ACK;
            end else begin
              drv_n   = 1'b1;
              wstb_n  = 1'b1;
              waddr_n = ptr;
              wdata_n = rx;
              if (PG_W < PTR_W) begin
                ptr_n = {ptr[PTR_W-1:PG_W], pg_lo};
              end else begin
                ptr_n = ptr + 1'b1;
              end
              st_n = ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw) begin
              tx_n  = {rdata[6:0], 1'b0};
              drv_n = ~rdata[7];
              ptr_n = ptr + 1'b1;
              st_n  = ST_TX;
            end else begin
              drv_n = 1'b0;
              st_n  = ST_WORD;
            end
          end
        end
        ST_WORD_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            drv_n = 1'b0;
            cnt_n = '0;
            st_n  = ST_WDATA;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_n = cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              drv_n = 1'b0;
              st_n  = ST_MACK;
            end else begin
              drv_n = ~tx[7];
              tx_n  = {tx[6:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack) begin
              cnt_n = '0;
              tx_n  = {rdata[6:0], 1'b0};
              drv_n = ~rdata[7];
              ptr_n = ptr + 1'b1;
              st_n  = ST_TX;
            end else begin
              drv_n = 1'b0;
              st_n  = ST_IDLE;
            end
          end
        end
        default: begin
          drv_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      rx      <= '0;
      tx      <= '0;
      ptr     <= '0;
      drv     <= 1'b0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      wr_stb  <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      rx      <= rx_n;
      tx      <= tx_n;
      ptr     <= ptr_n;
      drv     <= drv_n;
      rw      <= rw_n;
      mack    <= mack_n;
      wr_stb  <= wstb_n;
      waddr_q <= waddr_n;
      wdata_q <= wdata_n;
    end
  end

  assign sda_pull = drv;
  assign wr_addr  = waddr_q;
  assign wr_data  = wdata_q;

  // R9: the pull changes only after a detected SCL fall (or a bus condition)
  assert_pull_on_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> $past(scl_fall | bus_start | bus_stop));

  // R2: any start rearms address reception with the bus released
  assert_start_rearms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (st == ST_DEV && cnt == 4'd0 && !sda_pull));

  // R1: an unselected or idle engine leaves the bus and the array alone
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!sda_pull && !wr_stb));

  // R3: a write strobe only comes with the acknowledge of a data byte
  assert_wstb_in_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (st == ST_WDATA_ACK && sda_pull));

  // R4: stepping after a written byte keeps the page bits
  assert_page_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (ptr[PTR_W-1:PG_W] == wr_addr[PTR_W-1:PG_W]));

endmodule

// File: tb/ee_i2c_slave_bench.sv
module ee_i2c_slave_bench;

  localparam int H = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic pull_a, pull_b;
  logic stb_a, stb_b;
  logic [7:0] wa_a;
  logic [6:0] wa_b;
  logic [7:0] wd_a, wd_b;
  wire sda_bus = sda_m & ~pull_a & ~pull_b;

  ee_i2c_slave u_ee_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .dev_sel(3'b010), .sda_pull(pull_a), .wr_stb(stb_a),
    .wr_addr(wa_a), .wr_data(wd_a));

  ee_i2c_slave #(.SMALL_ARRAY(1'b1)) u_small (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .dev_sel(3'b101), .sda_pull(pull_b), .wr_stb(stb_b),
    .wr_addr(wa_b), .wr_data(wd_b));

  int checks = 0;
  int bad = 0;
  int strobes_a = 0;
  int strobes_b = 0;
  int viol = 0;
  logic [7:0] last_a_addr, last_a_data;
  logic [6:0] last_b_addr;
  logic [7:0] last_b_data;
  logic prev_pull;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (stb_a) begin strobes_a++; last_a_addr = wa_a; last_a_data = wd_a; end
    if (stb_b) begin strobes_b++; last_b_addr = wa_b; last_b_data = wd_b; end
    if (rst_n && prev_pull !== (pull_a | pull_b) && scl_m) viol++;
    prev_pull = pull_a | pull_b;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) % 256);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; tick(H);
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H / 2);
    @(negedge clk) acked = !sda_bus;
    tick(H / 2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl_m = 1'b1; tick(H / 2);
      @(negedge clk) b[i] = sda_bus;
      tick(H / 2);
      scl_m = 1'b0; tick(2);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    scl_m = 1'b0; tick(2);
    sda_m = 1'b1;
  endtask

  // write-mode device byte plus word address; leaves the bus mid-transaction
  task automatic set_ptr(input logic [7:0] dev, input logic [7:0] word, input string tag);
    bit ak;
    bus_start();
    send_byte(dev, ak); chk(ak, tag, ak, 1);
    send_byte(word, ak); chk(ak, tag, ak, 1);
  endtask

  initial begin
    tick(190000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] d;
    int s0;
    rst_n = 1'b0;
    tick(4);
    @(negedge clk);
    chk(!pull_a && !pull_b && !stb_a && !stb_b, "R10 reset outputs", {pull_a, pull_b, stb_a, stb_b}, 0);
    rst_n = 1'b1;
    tick(4);
    @(negedge clk);
    chk(!pull_a && !pull_b && !stb_a, "R10 after release", {pull_a, pull_b, stb_a}, 0);

    // R1: nobody answers 1010_111_0; following bytes are ignored
    bus_start();
    send_byte(8'hAE, ak); chk(!ak, "R1 mismatch no ack", ak, 0);
    send_byte(8'h00, ak); chk(!ak, "R1 ignored byte", ak, 0);
    send_byte(8'h33, ak); chk(!ak, "R1 ignored byte", ak, 0);
    bus_stop();
    chk(strobes_a == 0 && strobes_b == 0, "R1 no write on mismatch", strobes_a + strobes_b, 0);

    // R3: fill the whole large array page by page
    for (int p = 0; p < 32; p++) begin
      set_ptr(8'hA4, 8'(p * 8), "R3 addr ack");
      for (int k = 0; k < 8; k++) begin
        send_byte(pat(p * 8 + k), ak);
        chk(ak, "R3 data ack", ak, 1);
        chk(last_a_addr == 8'(p * 8 + k) && last_a_data == pat(p * 8 + k),
            "R3 strobe", {last_a_addr, last_a_data}, {8'(p * 8 + k), pat(p * 8 + k)});
      end
      bus_stop();
    end
    chk(strobes_a == 256, "R3 strobe count", strobes_a, 256);

    // R6 + R7: random read from 0, sequential through the wrap
    set_ptr(8'hA4, 8'h00, "R6 dummy write");
    bus_start();
    send_byte(8'hA5, ak); chk(ak, "R6 read ack", ak, 1);
    for (int i = 0; i < 260; i++) begin
      recv_byte(i < 259, d);
      chk(d == pat(i % 256), i == 0 ? "R6 first byte" : "R7 sequential", d, pat(i % 256));
    end
    tick(H);
    @(negedge clk);
    chk(!pull_a, "R7 released after nack", pull_a, 0);
    bus_stop();

    // R5: current-address reads continue from last location + 1
    bus_start();
    send_byte(8'hA5, ak); chk(ak, "R5 ack", ak, 1);
    recv_byte(1'b0, d); chk(d == pat(4), "R5 current read", d, pat(4));
    bus_stop();
    bus_start();
    send_byte(8'hA5, ak);
    recv_byte(1'b0, d); chk(d == pat(5), "R5 current read again", d, pat(5));
    bus_stop();

    // R4: ten bytes from 0x2E wrap inside page 0x28..0x2F
    set_ptr(8'hA4, 8'h2E, "R4 addr");
    for (int k = 0; k < 10; k++) begin
      send_byte(8'(8'hC0 + k), ak);
      chk(last_a_addr == (8'h28 | 8'((6 + k) % 8)), "R4 page wrap address",
          last_a_addr, 8'h28 | 8'((6 + k) % 8));
    end
    bus_stop();
    set_ptr(8'hA4, 8'h28, "R4 read setup");
    bus_start();
    send_byte(8'hA5, ak);
    for (int j = 0; j < 9; j++) begin
      recv_byte(j < 8, d);
      if (j < 8) chk(d == 8'(8'hC2 + j), "R4 page contents", d, 8'hC2 + j);
      else chk(d == pat(8'h30), "R4 next page untouched", d, pat(8'h30));
    end
    bus_stop();

    // R2: start in the middle of a data byte aborts without writing
    s0 = strobes_a;
    set_ptr(8'hA4, 8'h50, "R2 setup");
    send_bits(8'hFF, 4);
    bus_start();
    send_byte(8'hA5, ak); chk(ak, "R2 rearmed ack", ak, 1);
    recv_byte(1'b0, d); chk(d == pat(8'h50), "R2 aborted byte not written", d, pat(8'h50));
    bus_stop();
    chk(strobes_a == s0, "R2 no strobe", strobes_a, s0);

    // R3: word address with no data moves only the pointer
    set_ptr(8'hA4, 8'h60, "R3 pointer only");
    bus_stop();
    chk(strobes_a == s0, "R3 no strobe for address", strobes_a, s0);
    bus_start();
    send_byte(8'hA5, ak);
    recv_byte(1'b0, d); chk(d == pat(8'h60), "R3 pointer loaded", d, pat(8'h60));
    bus_stop();

    // R8: small instance masks the address MSB and wraps at 127
    set_ptr(8'hAA, 8'h85, "R8 addr");
    send_byte(8'h3C, ak); chk(ak, "R8 data ack", ak, 1);
    chk(last_b_addr == 7'h05 && last_b_data == 8'h3C, "R8 msb ignored", last_b_addr, 5);
    bus_stop();
    set_ptr(8'hAA, 8'h7F, "R8 top");
    send_byte(8'h99, ak);
    bus_stop();
    set_ptr(8'hAA, 8'h00, "R8 bottom");
    send_byte(8'h11, ak);
    bus_stop();
    set_ptr(8'hAA, 8'h7F, "R8 read setup");
    bus_start();
    send_byte(8'hAB, ak); chk(ak, "R8 read ack", ak, 1);
    recv_byte(1'b1, d); chk(d == 8'h99, "R8 location 127", d, 8'h99);
    recv_byte(1'b0, d); chk(d == 8'h11, "R8 wrap to 0", d, 8'h11);
    bus_stop();
    set_ptr(8'hAA, 8'h85, "R8 masked read");
    bus_start();
    send_byte(8'hAB, ak);
    recv_byte(1'b0, d); chk(d == 8'h3C, "R8 masked read data", d, 8'h3C);
    bus_stop();
    chk(strobes_a == s0, "R1 other device untouched", strobes_a, s0);
    set_ptr(8'hA4, 8'h05, "R1 isolation");
    bus_start();
    send_byte(8'hA5, ak);
    recv_byte(1'b0, d); chk(d == pat(5), "R1 isolation data", d, pat(5));
    bus_stop();

    chk(viol == 0, "R9 pull changed while SCL high", viol, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule